// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the slave-side logic of a byte-addressed serial EEPROM that a host reaches over SPI in clock modes 0 and 3. Every SPI pin is brought into the system clock domain through a synchronizer. SCK edges and chip-select edges are found in that domain. An 8-bit instruction is collected and decoded, and the block then runs an address phase and a data phase. It also keeps a small status register: a busy flag, a write-enable latch and a write-protect enable bit. The memory is a synchronous byte array written so that block RAM can be inferred. A counter of configurable length stands in for the internal programming time.

A host sets the write-enable latch in one session, then writes one byte or the status register in a later session. The host polls the status register until the busy flag drops. A read session returns consecutive bytes for as long as SCK runs, and the address wraps at the top of the array. A pause pin lets the host freeze a transfer mid-byte and resume it later.

Top module: `spi_ee_slave`

## Requirements
- R1: After reset `so_oe` is 0 and a status read (opcode 0x05) returns 0x00. The status byte layout is bit 0 busy, bit 1 write-enable latch, bit 7 protect enable, and bits 6..2 read 0.
- R2: Bits on `si` are taken on rising SCK, MSB first, and `so` changes after falling SCK. The same sessions work with SCK idling low (mode 0) and idling high (mode 3).
- R3: After an opcode other than 0x06, 0x04, 0x05, 0x01, 0x03 or 0x02, the rest of that session is ignored. `so_oe` stays 0 and no later byte is decoded as a command.
- R4: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. A write (0x02) made while the latch is clear changes nothing and starts no busy period.
- R5: A write session of opcode 0x02, a 16-bit address and exactly one data byte, made while the latch is set, stores the byte when `cs_n` rises. Busy then reads 1 for BUSY_CYCLES clocks, and at the end both busy and the latch clear.
- R6: While busy, every opcode except the status read is ignored. A read drives nothing and a write does not alter memory.
- R7: A read (0x03) with a 16-bit address returns bytes from successive addresses. Only the low ADDR_W bits of the address are used, so the address wraps from 2^ADDR_W-1 to 0 (0x7FF to 0x000 by default).
- R8: A status write (0x01) with one data byte, made while the latch is set, copies data bit 7 into the protect enable bit and starts a busy period. Other data bits have no effect, and without the latch the write is dropped.
- R9: When `wp_n` is 0 and the protect enable bit is 1, a status write is dropped, starts no busy period and leaves the latch set. When `wp_n` is 1, the status write goes ahead.
- R10: Pulling `hold_n` low while SCK is low forces `so_oe` to 0 and makes SCK edges ignored. Raising `hold_n` with SCK low resumes the transfer at the bit where it stopped.
- R11: A write session whose data phase is not exactly 8 bits is discarded. No busy period starts and the latch stays set.
- R12: `so_oe` is 0 whenever `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | SPI serial clock from the host |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data into the slave |
| hold_n | input | 1 | Pause request, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| so | output | 1 | Serial data out of the slave |
| so_oe | output | 1 | Output enable for `so`; 0 means high impedance |

## Verification
The assertions assume that every SCK half period and every gap between a chip-select edge and an SCK edge lasts many system clocks. This way a memory fetch started on a rising edge lands before the next falling edge, and a pause never begins within two clocks of a rising edge. They also assume that `hold_n` changes only while SCK is low. The stimulus keeps each SCK phase at eight system clocks, moves every pin on the falling system clock edge, and toggles `hold_n` only after SCK has been low for a full half period.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  localparam logic [7:0] OP_LATCH_ON  = 8'h06;
  localparam logic [7:0] OP_LATCH_OFF = 8'h04;
  localparam logic [7:0] OP_STAT_RD   = 8'h05;
  localparam logic [7:0] OP_STAT_WR   = 8'h01;
  localparam logic [7:0] OP_MEM_RD    = 8'h03;
  localparam logic [7:0] OP_MEM_WR    = 8'h02;

  typedef enum logic [2:0] {
    PH_OPCODE,
    PH_ADDR,
    PH_RDATA,
    PH_WDATA,
    PH_SRD,
    PH_SWR,
    PH_SKIP
  } ee_phase_t;

endpackage

// File: rtl/spi_ee_frontend.sv
module spi_ee_frontend #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_start,
  output logic cs_end,
  output logic cs_active,
  output logic hold_active,
  output logic si_s,
  output logic wp_n_s
);
  localparam int NPIN = 5;
  // pin order: {sck, cs_n, si, hold_n, wp_n}
  localparam logic [NPIN-1:0] IDLE_V = 5'b01011;

  logic [NPIN-1:0] stg [SYNC_STAGES];
  logic [NPIN-1:0] pins_s;
  logic sck_d, csn_d, hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= IDLE_V;
    end else begin
      stg[0] <= {sck, cs_n, si, hold_n, wp_n};
      for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign pins_s = stg[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d  <= 1'b0;
      csn_d  <= 1'b1;
      hold_q <= 1'b0;
    end else begin
      sck_d <= pins_s[4];
      csn_d <= pins_s[3];
      if (!pins_s[4]) hold_q <= !pins_s[1];
    end
  end

  assign cs_active   = !pins_s[3];
  assign hold_active = hold_q;
  assign sck_rise    = pins_s[4] && !sck_d && cs_active && !hold_q;
  assign sck_fall    = !pins_s[4] && sck_d && cs_active && !hold_q;
  assign cs_start    = !pins_s[3] && csn_d;
  assign cs_end      = pins_s[3] && !csn_d;
  assign si_s        = pins_s[2];
  assign wp_n_s      = pins_s[0];

endmodule

// File: rtl/spi_ee_mem.sv
module spi_ee_mem #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
    if (re) rdata <= cells[addr];
  end

endmodule

// File: rtl/spi_ee_busy.sv
module spi_ee_busy #(
  parameter int CYCLES = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (start)          cnt <= CW'(CYCLES);
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));

  assert_busy_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(CYCLES));
  assert_busy_follows_start_R5: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

endmodule

// File: rtl/spi_ee_slave.sv
module spi_ee_slave
  import spi_ee_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int ADDR_PHASE_W = 16,
  parameter int BUSY_CYCLES  = 2000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  localparam int CNT_W = $clog2(ADDR_PHASE_W);

  logic sck_rise, sck_fall, cs_start, cs_end, cs_active, hold_active, si_s, wp_n_s;
  logic busy, busy_done, busy_start;
  logic mem_we, rd_req, ld_pend;
  logic [7:0] mem_rdata;
  logic [ADDR_W-1:0] mem_addr;

  ee_phase_t phase;
  logic [CNT_W-1:0] bitcnt;
  logic [3:0] dcnt;
  logic [7:0] sh, sh_nx, out_sh, status;
  logic [ADDR_PHASE_W-2:0] addr_sh;
  logic [ADDR_PHASE_W-1:0] addr_nx;
  logic is_read, wel, wpen, so_r, oe_r;

  spi_ee_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .wp_n(wp_n), .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_start(cs_start),
    .cs_end(cs_end), .cs_active(cs_active), .hold_active(hold_active),
    .si_s(si_s), .wp_n_s(wp_n_s)
  );

  spi_ee_mem #(.ADDR_W(ADDR_W), .DATA_W(8)) u_mem (
    .clk(clk), .we(mem_we), .re(rd_req), .addr(mem_addr),
    .wdata(sh), .rdata(mem_rdata)
  );

  spi_ee_busy #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst(rst), .start(busy_start), .busy(busy), .done(busy_done)
  );

  assign sh_nx   = {sh[6:0], si_s};
  assign addr_nx = {addr_sh, si_s};
  assign status  = {wpen, 5'b0, wel, busy};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_SKIP;
      bitcnt     <= '0;
      dcnt       <= '0;
      sh         <= '0;
      addr_sh    <= '0;
      mem_addr   <= '0;
      out_sh     <= '0;
      so_r       <= 1'b0;
      oe_r       <= 1'b0;
      is_read    <= 1'b0;
      wel        <= 1'b0;
      wpen       <= 1'b0;
      rd_req     <= 1'b0;
      ld_pend    <= 1'b0;
      mem_we     <= 1'b0;
      busy_start <= 1'b0;
    end else begin
      rd_req     <= 1'b0;
      mem_we     <= 1'b0;
      busy_start <= 1'b0;
      ld_pend    <= rd_req;
      oe_r       <= cs_active && !hold_active && (phase == PH_RDATA || phase == PH_SRD);
      if (ld_pend) out_sh <= mem_rdata;
      if (busy_done) wel <= 1'b0;

      if (cs_start) begin
        phase  <= PH_OPCODE;
        bitcnt <= '0;
        dcnt   <= '0;
      end else if (cs_end) begin
        if (phase == PH_WDATA && dcnt == 4'd8 && wel) begin
          mem_we     <= 1'b1;
          busy_start <= 1'b1;
        end
        if (phase == PH_SWR && dcnt == 4'd8 && wel && !(wpen && !wp_n_s)) begin
          wpen       <= sh[7];
          busy_start <= 1'b1;
        end
        phase <= PH_SKIP;
      end else if (sck_rise) begin
        sh     <= sh_nx;
        bitcnt <= bitcnt + 1'b1;
        case (phase)
          PH_OPCODE: if (bitcnt == CNT_W'(7)) begin
            bitcnt <= '0;
            if (busy && sh_nx != OP_STAT_RD) phase <= PH_SKIP;
            else begin
              case (sh_nx)
                OP_LATCH_ON:  begin wel <= 1'b1; phase <= PH_SKIP; end
                OP_LATCH_OFF: begin wel <= 1'b0; phase <= PH_SKIP; end
                OP_STAT_RD:   begin out_sh <= status; phase <= PH_SRD; end
                OP_STAT_WR:   phase <= PH_SWR;
                OP_MEM_RD:    begin is_read <= 1'b1; phase <= PH_ADDR; end
                OP_MEM_WR:    begin is_read <= 1'b0; phase <= PH_ADDR; end
                default:      phase <= PH_SKIP;
              endcase
            end
          end
          PH_ADDR: begin
            addr_sh <= addr_nx[ADDR_PHASE_W-2:0];
            if (bitcnt == CNT_W'(ADDR_PHASE_W-1)) begin
              bitcnt   <= '0;
              mem_addr <= addr_nx[ADDR_W-1:0];
              rd_req   <= is_read;
              phase    <= is_read ? PH_RDATA : PH_WDATA;
            end
          end
          PH_RDATA: if (bitcnt == CNT_W'(7)) begin
            bitcnt   <= '0;
            mem_addr <= mem_addr + 1'b1;
            rd_req   <= 1'b1;
          end
          PH_SRD: if (bitcnt == CNT_W'(7)) begin
            bitcnt <= '0;
            out_sh <= status;
          end
          PH_WDATA, PH_SWR: if (dcnt != 4'd15) dcnt <= dcnt + 1'b1;
          default: ;
        endcase
      end else if (sck_fall) begin
        so_r   <= out_sh[7];
        out_sh <= {out_sh[6:0], 1'b0};
      end
    end
  end

  assign so    = so_r;
  assign so_oe = oe_r;

  assert_wel_drops_after_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    busy_done |=> !wel);
  assert_start_only_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
    busy_start |-> !busy);
  assert_no_fetch_while_busy_R6: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> !busy);
  assert_hold_freezes_shift_R10: assert property (@(posedge clk) disable iff (rst)
    (hold_active && $past(hold_active)) |-> ($stable(out_sh) && $stable(so_r)));
  assert_wpen_needs_latch_R8: assert property (@(posedge clk) disable iff (rst)
    (wpen != $past(wpen)) |-> $past(wel));

endmodule

// File: tb/spi_ee_slave_tb.sv
module spi_ee_slave_tb;
  localparam int AW    = 11;
  localparam int DEPTH = 1 << AW;
  localparam int BUSY  = 600;
  localparam int HALF  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
  logic so, so_oe;
  logic mode3 = 1'b0;
  logic oe_seen;
  logic finished = 1'b0;

  int nchk = 0, nfail = 0;
  logic [7:0] model [int];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] obs_q [$];

  always #2 clk = ~clk;

  spi_ee_slave #(.ADDR_W(AW), .BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .wp_n(wp_n), .so(so), .so_oe(so_oe)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sbit(input logic b, output logic o);
    sck = 1'b0;
    si  = b;
    wait_clk(HALF);
    o = so;
    oe_seen = oe_seen | so_oe;
    sck = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) sbit(tx[i], rx[i]);
  endtask

  task automatic sbegin();
    sck = mode3;
    wait_clk(HALF);
    oe_seen = 1'b0;
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] d;
    xbyte(tx, d);
  endtask

  task automatic send_addr(input logic [15:0] a);
    send(a[15:8]);
    send(a[7:0]);
  endtask

  task automatic send_end();
    if (!mode3) begin
      sck = 1'b0;
      wait_clk(HALF);
    end
    cs_n = 1'b1;
    wait_clk(4);
    check("R12 oe low with cs high", so_oe, 1'b0);
    wait_clk(2 * HALF);
  endtask

  task automatic cmd(input logic [7:0] op);
    sbegin(); send(op); send_end();
  endtask

  task automatic rdsr(output logic [7:0] st);
    sbegin(); send(8'h05); xbyte(8'h00, st); send_end();
  endtask

  task automatic chk_status(input string req, input logic [7:0] exp);
    logic [7:0] st;
    rdsr(st);
    check(req, st, exp);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic commit);
    sbegin(); send(8'h02); send_addr(a); send(d); send_end();
    if (commit) model[int'(a) % DEPTH] = d;
  endtask

  task automatic wr_ok(input logic [15:0] a, input logic [7:0] d);
    cmd(8'h06);
    wr(a, d, 1'b1);
    wait_clk(BUSY + 50);
  endtask

  task automatic rd(input logic [15:0] a, input int n, input string req);
    logic [7:0] d;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(model[(int'(a) + k) % DEPTH]);
      tag_q.push_back(req);
    end
    sbegin(); send(8'h03); send_addr(a);
    for (int k = 0; k < n; k++) begin
      xbyte(8'h00, d);
      obs_q.push_back(d);
    end
    send_end();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0) begin
        logic [7:0] o, e;
        string t;
        o = obs_q.pop_front();
        if (exp_q.size() == 0) begin
          check("scoreboard unexpected byte", o, 8'hxx);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, o, e);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] st, d;
    wait_clk(10);
    rst = 1'b0;
    wait_clk(5);
    check("R1 reset oe", so_oe, 1'b0);
    chk_status("R1 reset status", 8'h00);

    // R4 latch set and clear
    cmd(8'h06);
    chk_status("R4 latch set", 8'h02);
    cmd(8'h04);
    chk_status("R4 latch cleared", 8'h00);

    // R5 committed write, busy, latch clear at end
    cmd(8'h06);
    wr(16'h0010, 8'h5A, 1'b1);
    chk_status("R5 busy with latch", 8'h03);
    wait_clk(BUSY + 50);
    chk_status("R5 idle latch cleared", 8'h00);

    // R4 write without latch dropped
    wr(16'h0010, 8'h11, 1'b0);
    chk_status("R4 no busy without latch", 8'h00);
    rd(16'h0010, 1, "R4 memory unchanged");

    // R11 partial data phase discarded
    cmd(8'h06);
    sbegin(); send(8'h02); send_addr(16'h0010);
    for (int i = 0; i < 5; i++) sbit(1'b1, d[0]);
    send_end();
    chk_status("R11 no busy latch kept", 8'h02);
    sbegin(); send(8'h02); send_addr(16'h0010); send(8'hEE); sbit(1'b0, d[0]);
    send_end();
    chk_status("R11 nine bits no busy", 8'h02);
    rd(16'h0010, 1, "R11 memory unchanged");
    cmd(8'h04);

    // R7 increment, wrap and address masking
    wr_ok(16'h0011, 8'hC3);
    wr_ok(16'h07FF, 8'hA5);
    wr_ok(16'hF800, 8'h3C);
    rd(16'h0010, 2, "R7 increment");
    rd(16'h07FF, 2, "R7 wrap");
    rd(16'hF810, 1, "R7 upper bits ignored");

    // R2 mode 3
    mode3 = 1'b1;
    rd(16'h07FF, 3, "R2 mode3 read");
    wr_ok(16'h0020, 8'h96);
    rd(16'h0020, 1, "R2 mode3 write");
    chk_status("R2 mode3 status", 8'h00);
    mode3 = 1'b0;

    // R3 unknown opcode ignores session
    sbegin(); send(8'hFF); send(8'h03); send(8'h00); send(8'h10);
    xbyte(8'h00, d);
    check("R3 no drive after bad opcode", oe_seen, 1'b0);
    send_end();
    sbegin(); send(8'hAB); send(8'h06); send_end();
    chk_status("R3 embedded opcode ignored", 8'h00);

    // R6 busy ignores non-status opcodes
    cmd(8'h06);
    wr(16'h0030, 8'h77, 1'b1);
    sbegin(); send(8'h03); send_addr(16'h0010); xbyte(8'h00, d);
    check("R6 read ignored while busy", oe_seen, 1'b0);
    send_end();
    wr(16'h0030, 8'h99, 1'b0);
    wait_clk(BUSY + 50);
    chk_status("R6 no second cycle", 8'h00);
    rd(16'h0030, 1, "R6 memory kept");

    // R8 status write
    sbegin(); send(8'h01); send(8'h80); send_end();
    chk_status("R8 dropped without latch", 8'h00);
    cmd(8'h06);
    sbegin(); send(8'h01); send(8'h8C); send_end();
    chk_status("R8 busy after status write", 8'h83);
    wait_clk(BUSY + 50);
    chk_status("R8 only bit7 taken", 8'h80);

    // R9 pin plus bit protection
    wp_n = 1'b0;
    cmd(8'h06);
    sbegin(); send(8'h01); send(8'h00); send_end();
    chk_status("R9 blocked keeps latch", 8'h82);
    wp_n = 1'b1;
    sbegin(); send(8'h01); send(8'h00); send_end();
    wait_clk(BUSY + 50);
    chk_status("R9 allowed with pin high", 8'h00);

    // R10 pause mid byte
    exp_q.push_back(model[16]); tag_q.push_back("R10 byte across pause");
    exp_q.push_back(model[17]); tag_q.push_back("R10 byte after pause");
    sbegin(); send(8'h03); send_addr(16'h0010);
    for (int i = 7; i >= 4; i--) sbit(1'b0, d[i]);
    sck = 1'b0;
    wait_clk(HALF);
    hold_n = 1'b0;
    wait_clk(HALF);
    check("R10 oe low in pause", so_oe, 1'b0);
    for (int i = 0; i < 3; i++) begin
      sck = 1'b1; wait_clk(HALF);
      sck = 1'b0; wait_clk(HALF);
    end
    check("R10 oe still low", so_oe, 1'b0);
    hold_n = 1'b1;
    wait_clk(HALF);
    for (int i = 3; i >= 0; i--) sbit(1'b0, d[i]);
    obs_q.push_back(d);
    xbyte(8'h00, st);
    obs_q.push_back(st);
    send_end();

    wait_clk(20);
    check("scoreboard drained", exp_q.size(), 0);
    summary();
  end

endmodule